// File: doc/BRIEF.md
# Two-Level Translation Tag Lookup

This block holds translation tags and answers, for a virtual address, whether a stored entry covers it and which entry that is. Storage has two levels. The first is a set-associative array whose page size is one shared value supplied with every lookup. The second is a small fully associative array in which every entry keeps its own page size. Each entry describes an even/odd pair of pages, so the bit just above the page offset does not take part in the compare.

A lookup presents the address, the current address-space identifier and the shared page size on one cycle. All ways of the selected set and all fully associative entries are compared in parallel in that cycle. The result is registered and appears on the next cycle. A write port loads the tag, identifier, global flag, existence flag and, for the second level, the page size of one entry chosen by a flat index. Permission checks and refill are handled elsewhere.

The response logic is a four-state machine. The state is set on every clock. It goes to `ST_IDLE` when no lookup was requested. On a lookup it goes to `ST_SA_HIT` when the first level matched, to `ST_FA_HIT` when only the second level matched, and to `ST_MISS` otherwise. Any state can reach any other state on the next clock.

Top module: `tlb2_lookup`

## Requirements
- R1: Reset (`rst_n` low) clears every existence flag and the response. After reset `rsp_valid` is 0, and a lookup misses until an entry is written.
- R2: `rsp_valid` is 1 exactly in the cycle after a cycle with `lk_req` high, and 0 otherwise.
- R3: The first-level set is the low 8 bits of (masked VA >> (PS+1)), where PS is `lk_ps`. The flat index of a first-level entry is way×256 + set.
- R4: An entry whose existence flag is 0 never matches.
- R5: An entry matches only if its global flag is 1 or its stored identifier equals `lk_asid`.
- R6: A stored tag holds VA bits 47..13. The compare checks (tag >> (PS+1−13)) against (VA >> (PS+1)). Both pages of an even/odd pair therefore hit the same entry.
- R7: The first level has priority. The second level answers only when the first level misses. Second-level flat indices start at 2048.
- R8: Each second-level entry uses its own stored page size. It does not use `lk_ps`.
- R9: VA bits 63..48 are ignored.
- R10: When several entries match, the lowest flat index is reported.
- R11: A miss gives `rsp_hit` = 0 and `rsp_idx` = 0.
- R12: A write to an index of 2112 or more changes nothing. A lookup in the same cycle as a write sees the old contents. A lookup in the following cycle sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 64 | Virtual address |
| lk_asid | input | 10 | Current address-space identifier |
| lk_ps | input | 6 | Shared page size (log2 bytes, 12 or more) |
| wr_en | input | 1 | Entry write enable |
| wr_idx | input | 12 | Flat entry index to write |
| wr_tag | input | 35 | VA bits 47..13 of the pair |
| wr_asid | input | 10 | Identifier to store |
| wr_glob | input | 1 | Global flag to store |
| wr_exist | input | 1 | Existence flag to store |
| wr_ps | input | 6 | Page size, used by second-level entries only |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | An entry matched |
| rsp_idx | output | 12 | Flat index of the matching entry |

## Verification
Every response is due exactly one clock after the cycle that carries `lk_req`. Writes take effect at the clock edge that captures them, so a lookup in the next cycle sees the new entry. The bench drives inputs on the falling edge and drops the request on the following falling edge. It samples the response at that same falling edge, which lies after the one rising edge that registers the result. An extra sample one cycle later confirms that `rsp_valid` has dropped again.

// File: rtl/tlb2_pkg.sv
package tlb2_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SA_HIT,
        ST_FA_HIT,
        ST_MISS
    } lk_state_t;

endpackage

// File: rtl/tlb2_pair_cmp.sv
module tlb2_pair_cmp #(
    parameter int VA_W    = 48,
    parameter int TAG_LSB = 13,
    parameter int PS_W    = 6,
    localparam int TAG_W  = VA_W - TAG_LSB,
    localparam int SH_W   = PS_W + 1
) (
    input  logic [VA_W-1:0]  va,
    input  logic [TAG_W-1:0] tag,
    input  logic [PS_W-1:0]  ps,
    output logic             match
);
    logic [SH_W-1:0] va_sh;
    logic [SH_W-1:0] tag_sh;
    logic [VA_W-1:0] va_pair;
    logic [VA_W-1:0] tag_pair;

    always_comb begin
        va_sh    = SH_W'(ps) + SH_W'(1);
        tag_sh   = va_sh - SH_W'(TAG_LSB);
        va_pair  = va >> va_sh;
        tag_pair = {{TAG_LSB{1'b0}}, tag} >> tag_sh;
        match    = (va_pair == tag_pair);
    end
endmodule

// File: rtl/tlb2_sa_array.sv
module tlb2_sa_array #(
    parameter int WAYS    = 8,
    parameter int SETS    = 256,
    parameter int VA_W    = 48,
    parameter int TAG_LSB = 13,
    parameter int ASID_W  = 10,
    parameter int PS_W    = 6,
    localparam int TAG_W  = VA_W - TAG_LSB,
    localparam int SET_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int SH_W   = PS_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_glob,
    input  logic              wr_exist,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [PS_W-1:0]   lk_ps,
    output logic              hit,
    output logic [WAY_W-1:0]  hit_way,
    output logic [SET_W-1:0]  sel_set
);
    logic [WAYS-1:0] way_match;

    always_comb begin
        sel_set = SET_W'(lk_va >> (SH_W'(lk_ps) + SH_W'(1)));
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [TAG_W-1:0]  tag_q  [SETS];
        logic [ASID_W-1:0] asid_q [SETS];
        logic [SETS-1:0]   glob_q;
        logic [SETS-1:0]   ex_q;
        logic              tag_eq;
        logic              wsel;

        assign wsel = wr_en && (wr_way == WAY_W'(w));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ex_q <= '0;
            end else if (wsel) begin
                ex_q[wr_set] <= wr_exist;
            end
        end

        always_ff @(posedge clk) begin
            if (wsel) begin
                tag_q[wr_set]  <= wr_tag;
                asid_q[wr_set] <= wr_asid;
                glob_q[wr_set] <= wr_glob;
            end
        end

        tlb2_pair_cmp #(
            .VA_W    (VA_W),
            .TAG_LSB (TAG_LSB),
            .PS_W    (PS_W)
        ) u_cmp (
            .va    (lk_va),
            .tag   (tag_q[sel_set]),
            .ps    (lk_ps),
            .match (tag_eq)
        );

        assign way_match[w] = ex_q[sel_set] && tag_eq &&
                              (glob_q[sel_set] || (asid_q[sel_set] == lk_asid));
    end

    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (way_match[w]) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/tlb2_fa_array.sv
module tlb2_fa_array #(
    parameter int DEPTH   = 64,
    parameter int VA_W    = 48,
    parameter int TAG_LSB = 13,
    parameter int ASID_W  = 10,
    parameter int PS_W    = 6,
    localparam int TAG_W  = VA_W - TAG_LSB,
    localparam int ENT_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ENT_W-1:0]  wr_ent,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_glob,
    input  logic              wr_exist,
    input  logic [PS_W-1:0]   wr_ps,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              hit,
    output logic [ENT_W-1:0]  hit_ent
);
    logic [DEPTH-1:0] ent_match;

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        logic [TAG_W-1:0]  tag_q;
        logic [ASID_W-1:0] asid_q;
        logic [PS_W-1:0]   ps_q;
        logic              glob_q;
        logic              ex_q;
        logic              tag_eq;
        logic              wsel;

        assign wsel = wr_en && (wr_ent == ENT_W'(e));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ex_q <= 1'b0;
            end else if (wsel) begin
                ex_q <= wr_exist;
            end
        end

        always_ff @(posedge clk) begin
            if (wsel) begin
                tag_q  <= wr_tag;
                asid_q <= wr_asid;
                ps_q   <= wr_ps;
                glob_q <= wr_glob;
            end
        end

        tlb2_pair_cmp #(
            .VA_W    (VA_W),
            .TAG_LSB (TAG_LSB),
            .PS_W    (PS_W)
        ) u_cmp (
            .va    (lk_va),
            .tag   (tag_q),
            .ps    (ps_q),
            .match (tag_eq)
        );

        assign ent_match[e] = ex_q && tag_eq && (glob_q || (asid_q == lk_asid));
    end

    always_comb begin
        hit     = 1'b0;
        hit_ent = '0;
        for (int e = DEPTH - 1; e >= 0; e--) begin
            if (ent_match[e]) begin
                hit     = 1'b1;
                hit_ent = ENT_W'(e);
            end
        end
    end
endmodule

// File: rtl/tlb2_lookup.sv
module tlb2_lookup
    import tlb2_pkg::*;
#(
    parameter int VA_IN_W  = 64,
    parameter int VA_W     = 48,
    parameter int WAYS     = 8,
    parameter int SETS     = 256,
    parameter int FA_DEPTH = 64,
    parameter int ASID_W   = 10,
    parameter int PS_W     = 6,
    parameter int TAG_LSB  = 13,
    localparam int TAG_W    = VA_W - TAG_LSB,
    localparam int SA_TOTAL = WAYS * SETS,
    localparam int TOTAL    = SA_TOTAL + FA_DEPTH,
    localparam int IDX_W    = $clog2(TOTAL),
    localparam int SET_W    = $clog2(SETS),
    localparam int WAY_W    = $clog2(WAYS),
    localparam int ENT_W    = $clog2(FA_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_req,
    input  logic [VA_IN_W-1:0] lk_va,
    input  logic [ASID_W-1:0]  lk_asid,
    input  logic [PS_W-1:0]    lk_ps,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic [ASID_W-1:0]  wr_asid,
    input  logic               wr_glob,
    input  logic               wr_exist,
    input  logic [PS_W-1:0]    wr_ps,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [IDX_W-1:0]   rsp_idx
);
    logic [VA_W-1:0]  va_m;
    logic             unused_va_hi;
    logic             wr_sa;
    logic             wr_fa;
    logic [IDX_W-1:0] fa_off;
    logic [ENT_W-1:0] wr_ent;

    logic             sa_hit;
    logic [WAY_W-1:0] sa_way;
    logic [SET_W-1:0] sa_set;
    logic             fa_hit;
    logic [ENT_W-1:0] fa_ent;

    lk_state_t        state_q;
    lk_state_t        state_d;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_d;

    assign va_m         = lk_va[VA_W-1:0];
    assign unused_va_hi = ^lk_va[VA_IN_W-1:VA_W];

    always_comb begin
        wr_sa  = wr_en && (wr_idx < IDX_W'(SA_TOTAL));
        wr_fa  = wr_en && !wr_sa && (wr_idx < IDX_W'(TOTAL));
        fa_off = wr_idx - IDX_W'(SA_TOTAL);
        wr_ent = ENT_W'(fa_off);
    end

    tlb2_sa_array #(
        .WAYS    (WAYS),
        .SETS    (SETS),
        .VA_W    (VA_W),
        .TAG_LSB (TAG_LSB),
        .ASID_W  (ASID_W),
        .PS_W    (PS_W)
    ) u_sa (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_sa),
        .wr_way   (wr_idx[SET_W +: WAY_W]),
        .wr_set   (wr_idx[SET_W-1:0]),
        .wr_tag   (wr_tag),
        .wr_asid  (wr_asid),
        .wr_glob  (wr_glob),
        .wr_exist (wr_exist),
        .lk_va    (va_m),
        .lk_asid  (lk_asid),
        .lk_ps    (lk_ps),
        .hit      (sa_hit),
        .hit_way  (sa_way),
        .sel_set  (sa_set)
    );

    tlb2_fa_array #(
        .DEPTH   (FA_DEPTH),
        .VA_W    (VA_W),
        .TAG_LSB (TAG_LSB),
        .ASID_W  (ASID_W),
        .PS_W    (PS_W)
    ) u_fa (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_fa),
        .wr_ent   (wr_ent),
        .wr_tag   (wr_tag),
        .wr_asid  (wr_asid),
        .wr_glob  (wr_glob),
        .wr_exist (wr_exist),
        .wr_ps    (wr_ps),
        .lk_va    (va_m),
        .lk_asid  (lk_asid),
        .hit      (fa_hit),
        .hit_ent  (fa_ent)
    );

    // next state and the index that goes with it
    always_comb begin
        state_d = ST_IDLE;
        idx_d   = '0;
        if (lk_req) begin
            if (sa_hit) begin
                state_d = ST_SA_HIT;
                idx_d   = IDX_W'(sa_way) * IDX_W'(SETS) + IDX_W'(sa_set);
            end else if (fa_hit) begin
                state_d = ST_FA_HIT;
                idx_d   = IDX_W'(SA_TOTAL) + IDX_W'(fa_ent);
            end else begin
                state_d = ST_MISS;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        rsp_idx = idx_q;
        unique case (state_q)
            ST_IDLE:   begin rsp_valid = 1'b0; rsp_hit = 1'b0; end
            ST_SA_HIT: begin rsp_valid = 1'b1; rsp_hit = 1'b1; end
            ST_FA_HIT: begin rsp_valid = 1'b1; rsp_hit = 1'b1; end
            ST_MISS:   begin rsp_valid = 1'b1; rsp_hit = 1'b0; end
            default:   begin rsp_valid = 1'b0; rsp_hit = 1'b0; end
        endcase
    end
endmodule

// File: rtl/tlb2_lookup_chk.sv
module tlb2_lookup_chk #(
    parameter int IDX_W    = 12,
    parameter int SA_TOTAL = 2048,
    parameter int TOTAL    = 2112
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_req,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [IDX_W-1:0] rsp_idx
);
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !rsp_valid);

    p_req_gives_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid);

    p_no_req_no_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rsp_valid);

    p_idx_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_idx < IDX_W'(TOTAL)));

    p_miss_idx_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_idx == '0));

    p_hit_is_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);
endmodule

bind tlb2_lookup tlb2_lookup_chk #(
    .IDX_W    (IDX_W),
    .SA_TOTAL (SA_TOTAL),
    .TOTAL    (TOTAL)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_req    (lk_req),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_idx   (rsp_idx)
);

// File: tb/tlb2_lookup_bench.sv
`timescale 1ns/1ps
module tlb2_lookup_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [63:0] lk_va = '0;
    logic [9:0]  lk_asid = '0;
    logic [5:0]  lk_ps = 6'd13;
    logic        wr_en = 1'b0;
    logic [11:0] wr_idx = '0;
    logic [34:0] wr_tag = '0;
    logic [9:0]  wr_asid = '0;
    logic        wr_glob = 1'b0;
    logic        wr_exist = 1'b0;
    logic [5:0]  wr_ps = '0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [11:0] rsp_idx;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    tlb2_lookup u_tlb2_lookup (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_va(lk_va),
        .lk_asid(lk_asid), .lk_ps(lk_ps), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_tag(wr_tag), .wr_asid(wr_asid), .wr_glob(wr_glob),
        .wr_exist(wr_exist), .wr_ps(wr_ps), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_idx(rsp_idx)
    );

    typedef struct packed {
        logic [63:0] va;
        logic [9:0]  asid;
        logic [5:0]  ps;
        logic        hit;
        logic [11:0] idx;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{64'h14000,                10'd3, 6'd13, 1'b1, 12'd5},    // R3 R5
        '{64'h14000,                10'd4, 6'd13, 1'b1, 12'd261},  // R10 tie
        '{64'h14000,                10'd9, 6'd13, 1'b1, 12'd2050}, // R7
        '{64'h16000,                10'd3, 6'd13, 1'b1, 12'd5},    // R6 odd page
        '{64'h414000,               10'd1, 6'd13, 1'b1, 12'd517},  // R5 global
        '{64'hFFFF_0000_0001_4000,  10'd3, 6'd13, 1'b1, 12'd5},    // R9
        '{64'h40123456,             10'd3, 6'd13, 1'b1, 12'd2048}, // R8 R10
        '{64'h40123456,             10'd5, 6'd13, 1'b1, 12'd2051}, // R5
        '{64'h80000000,             10'd0, 6'd13, 1'b0, 12'd0},    // R4 R11
        '{64'h18000,                10'd3, 6'd13, 1'b0, 12'd0},    // R3 R11
        '{64'h14000,                10'd3, 6'd14, 1'b1, 12'd2050}  // R8 shared ps
    };

    task automatic put(input logic [11:0] idx, input logic [34:0] tag,
                       input logic [9:0] asid, input logic glob,
                       input logic ex, input logic [5:0] ps);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_tag = tag; wr_asid = asid;
        wr_glob = glob; wr_exist = ex; wr_ps = ps;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_rsp(input string req, input logic hit_e,
                              input logic [11:0] idx_e);
        total++;
        if (rsp_valid !== 1'b1 || rsp_hit !== hit_e || rsp_idx !== idx_e) begin
            bad++;
            $display("FAIL %s: valid=%b hit=%b idx=%0d expected valid=1 hit=%b idx=%0d",
                     req, rsp_valid, rsp_hit, rsp_idx, hit_e, idx_e);
        end
    endtask

    task automatic expect_idle(input string req);
        total++;
        if (rsp_valid !== 1'b0) begin
            bad++;
            $display("FAIL %s: valid=%b expected 0", req, rsp_valid);
        end
    endtask

    task automatic look(input logic [63:0] va, input logic [9:0] asid,
                        input logic [5:0] ps, input string req,
                        input logic hit_e, input logic [11:0] idx_e);
        @(negedge clk);
        lk_req = 1'b1; lk_va = va; lk_asid = asid; lk_ps = ps;
        @(negedge clk);
        lk_req = 1'b0;
        expect_rsp(req, hit_e, idx_e);
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_idle("R1 reset");
        look(64'h14000, 10'd3, 6'd13, "R1 empty after reset", 1'b0, 12'd0);
        @(negedge clk);
        expect_idle("R2 no request");

        put(12'd5,    35'hA,     10'd3, 1'b0, 1'b1, 6'd0);
        put(12'd261,  35'hA,     10'd4, 1'b0, 1'b1, 6'd0);
        put(12'd517,  35'h20A,   10'd7, 1'b1, 1'b1, 6'd0);
        put(12'd773,  35'hA,     10'd4, 1'b0, 1'b1, 6'd0);
        put(12'd2048, 35'h20000, 10'd3, 1'b0, 1'b1, 6'd21);
        put(12'd2049, 35'h40000, 10'd0, 1'b1, 1'b0, 6'd21);
        put(12'd2050, 35'hA,     10'd0, 1'b1, 1'b1, 6'd13);
        put(12'd2051, 35'h20000, 10'd0, 1'b1, 1'b1, 6'd21);

        for (int i = 0; i < NVEC; i++) begin
            look(VECS[i].va, VECS[i].asid, VECS[i].ps,
                 $sformatf("R3/R5-R11 vector %0d", i), VECS[i].hit, VECS[i].idx);
        end
        @(negedge clk);
        expect_idle("R2 drop after response");

        // R12: write and lookup in the same cycle see old contents
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 12'd1072; wr_tag = 35'h60; wr_asid = 10'd2;
        wr_glob = 1'b0; wr_exist = 1'b1; wr_ps = 6'd0;
        lk_req = 1'b1; lk_va = 64'hC0000; lk_asid = 10'd2; lk_ps = 6'd13;
        @(negedge clk);
        wr_en = 1'b0; lk_req = 1'b0;
        expect_rsp("R12 same-cycle write unseen", 1'b0, 12'd0);
        look(64'hC0000, 10'd2, 6'd13, "R12 write seen next cycle", 1'b1, 12'd1072);

        // R12: out-of-range write ignored
        put(12'd4095, 35'h1FE, 10'd0, 1'b1, 1'b1, 6'd21);
        look(64'h3FC000, 10'd0, 6'd13, "R12 out-of-range write", 1'b0, 12'd0);

        // R4: clearing existence removes the entry
        put(12'd5, 35'hA, 10'd3, 1'b0, 1'b0, 6'd0);
        look(64'h14000, 10'd3, 6'd13, "R4 cleared entry", 1'b1, 12'd2050);

        // R1: reset clears existence
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        expect_idle("R1 reset mid-run");
        look(64'h14000, 10'd9, 6'd13, "R1 entries cleared", 1'b0, 12'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule